// File: doc/BRIEF.md
# Keyboard Serial Frame Receiver

This block receives bytes from a keyboard that speaks the common two-wire serial protocol: the keyboard drives a slow clock line and a data line, and presents one bit for each clock period. The receiver brings both lines into the system clock domain, takes one bit on every falling edge of the keyboard clock, and assembles an 11-bit frame made of a low start bit, eight data bits sent least significant first, an odd parity bit and a high stop bit.

A frame that passes every framing and parity test produces its 8-bit scan code on `code` together with a strobe on `code_valid` lasting a single system clock. A bad start, parity or stop bit raises its own dedicated flag, and from then on the receiver ignores the lines entirely until the next reset. If the keyboard clock rests high for longer than a programmable idle window while a frame is only partly received, the partial frame is discarded and the next falling edge is treated as a fresh start bit.

Top module: `kbd_frame_rx`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `code` is 0 and `code_valid`, `err_start`, `err_parity`, `err_stop` are all 0.
- R2: For a well formed frame, `code` carries the eight data bits with the first transmitted data bit in bit 0, and `code_valid` is high for exactly one system clock per frame.
- R3: Parity is odd: the frame is accepted only if the parity bit equals the inverse of the XOR of the eight data bits; otherwise `err_parity` goes high and no strobe is produced.
- R4: A start bit sampled as 1 sets `err_start` and no strobe is produced for that frame.
- R5: A stop bit sampled as 0 sets `err_stop` and no strobe is produced for that frame.
- R6: Once any error flag is high it keeps its value, `code_valid` stays low and `code` keeps its value for any further line activity, until `rst`.
- R7: At most one of the three error flags is high at any time.
- R8: If the keyboard clock stays high for `IDLE_CYCLES` system clocks after at least one bit of a frame has arrived, the partial frame is dropped and a complete frame sent afterwards is decoded correctly.
- R9: Between strobes `code` holds the last accepted scan code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| kb_clk | input | 1 | Keyboard clock line, asynchronous, idles high |
| kb_dat | input | 1 | Keyboard data line, asynchronous, idles high |
| code | output | DATA_W | Last accepted scan code |
| code_valid | output | 1 | One-cycle strobe for a new scan code |
| err_start | output | 1 | Sticky flag: start bit was 1 |
| err_parity | output | 1 | Sticky flag: odd parity check failed |
| err_stop | output | 1 | Sticky flag: stop bit was 0 |

## Verification
The hardest situation to reach from the ports is the idle recovery: the bench must stop a frame after a few bits and then leave the keyboard clock high long enough for the window to expire, which a keyboard that always completes its frames never does. The stimulus sends a truncated frame, holds the clock high past `IDLE_CYCLES` (shortened for the bench), and then sends a full random frame whose code must come out intact. The error lock is reached by deliberately corrupting one framing field and then sending a good frame that must be ignored.

// File: rtl/kbd_rx_pkg.sv
package kbd_rx_pkg;
  typedef enum logic [0:0] {
    RX_RUN  = 1'b0,
    RX_LOCK = 1'b1
  } rx_state_t;

  localparam int LINE_CLK = 0;
  localparam int LINE_DAT = 1;
  localparam int NUM_LINES = 2;
endpackage

// File: rtl/kbd_sync.sv
module kbd_sync #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] pipe [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          pipe[s] <= '1;
        end else if (s == 0) begin
          pipe[s] <= din;
        end else begin
          pipe[s] <= pipe[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/kbd_fall_detect.sv
module kbd_fall_detect (
  input  logic clk,
  input  logic rst,
  input  logic line,
  output logic fall
);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
    end else if (line) begin
      armed <= 1'b1;
    end else begin
      armed <= 1'b0;
    end
  end

  assign fall = armed & ~line;
endmodule

// File: rtl/kbd_idle_timer.sv
module kbd_idle_timer #(
  parameter int LIMIT = 400000
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  output logic expire
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      cnt    <= '0;
      expire <= 1'b0;
    end else if (cnt == LAST) begin
      cnt    <= '0;
      expire <= 1'b1;
    end else begin
      cnt    <= cnt + 1'b1;
      expire <= 1'b0;
    end
  end
endmodule

// File: rtl/kbd_frame_fsm.sv
module kbd_frame_fsm
  import kbd_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_fall,
  input  logic              bit_val,
  input  logic              expire,
  output logic              mid_frame,
  output logic [DATA_W-1:0] code,
  output logic              code_valid,
  output logic              err_start,
  output logic              err_parity,
  output logic              err_stop
);
  localparam int FRAME_BITS = DATA_W + 3;
  localparam int IW = $clog2(FRAME_BITS);
  localparam logic [IW-1:0] IDX_PAR  = IW'(DATA_W + 1);
  localparam logic [IW-1:0] IDX_STOP = IW'(DATA_W + 2);

  rx_state_t         state;
  logic [IW-1:0]     idx;
  logic [DATA_W-1:0] shreg;
  logic              ones_odd;

  assign mid_frame = (state == RX_RUN) && (idx != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= RX_RUN;
      idx        <= '0;
      shreg      <= '0;
      ones_odd   <= 1'b0;
      code       <= '0;
      code_valid <= 1'b0;
      err_start  <= 1'b0;
      err_parity <= 1'b0;
      err_stop   <= 1'b0;
    end else begin
      code_valid <= 1'b0;
      if (state == RX_RUN) begin
        if (expire) begin
          idx      <= '0;
          ones_odd <= 1'b0;
        end else if (bit_fall) begin
          if (idx == '0) begin
            if (bit_val) begin
              err_start <= 1'b1;
              state     <= RX_LOCK;
            end else begin
              idx      <= idx + 1'b1;
              ones_odd <= 1'b0;
            end
          end else if (idx == IDX_PAR) begin
            if (bit_val == ones_odd) begin
              err_parity <= 1'b1;
              state      <= RX_LOCK;
            end else begin
              idx <= idx + 1'b1;
            end
          end else if (idx == IDX_STOP) begin
            if (!bit_val) begin
              err_stop <= 1'b1;
              state    <= RX_LOCK;
            end else begin
              code       <= shreg;
              code_valid <= 1'b1;
              idx        <= '0;
            end
          end else begin
            shreg    <= {bit_val, shreg[DATA_W-1:1]};
            ones_odd <= ones_odd ^ bit_val;
            idx      <= idx + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/kbd_frame_rx.sv
module kbd_frame_rx
  import kbd_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int IDLE_CYCLES = 400000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              kb_clk,
  input  logic              kb_dat,
  output logic [DATA_W-1:0] code,
  output logic              code_valid,
  output logic              err_start,
  output logic              err_parity,
  output logic              err_stop
);
  logic [NUM_LINES-1:0] raw_lines;
  logic [NUM_LINES-1:0] sync_lines;
  logic                 fall;
  logic                 mid_frame;
  logic                 expire;

  assign raw_lines[LINE_CLK] = kb_clk;
  assign raw_lines[LINE_DAT] = kb_dat;

  kbd_sync #(.STAGES(SYNC_STAGES), .W(NUM_LINES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (raw_lines),
    .dout (sync_lines)
  );

  kbd_fall_detect u_fall (
    .clk  (clk),
    .rst  (rst),
    .line (sync_lines[LINE_CLK]),
    .fall (fall)
  );

  kbd_idle_timer #(.LIMIT(IDLE_CYCLES)) u_idle (
    .clk    (clk),
    .rst    (rst),
    .active (mid_frame && sync_lines[LINE_CLK]),
    .expire (expire)
  );

  kbd_frame_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .bit_fall   (fall),
    .bit_val    (sync_lines[LINE_DAT]),
    .expire     (expire),
    .mid_frame  (mid_frame),
    .code       (code),
    .code_valid (code_valid),
    .err_start  (err_start),
    .err_parity (err_parity),
    .err_stop   (err_stop)
  );
endmodule

// File: rtl/kbd_frame_rx_chk.sv
module kbd_frame_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] code,
  input logic              code_valid,
  input logic              err_start,
  input logic              err_parity,
  input logic              err_stop
);
  logic [2:0] errs;
  assign errs = {err_start, err_parity, err_stop};

  // R2
  strobe_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    code_valid |=> !code_valid);

  // R7
  err_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(errs));

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (|errs) |=> $stable(errs));

  // R6
  no_strobe_locked_chk: assert property (@(posedge clk) disable iff (rst)
    (|errs) |=> (!code_valid && $stable(code)));

  // R9
  code_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !code_valid |-> $stable(code));
endmodule

bind kbd_frame_rx kbd_frame_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .code       (code),
  .code_valid (code_valid),
  .err_start  (err_start),
  .err_parity (err_parity),
  .err_stop   (err_stop)
);

// File: tb/kbd_frame_rx_test.sv
`timescale 1ns/1ps
module kbd_frame_rx_test;
  localparam int IDLE = 120;
  localparam int HALF = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       kb_clk = 1'b1;
  logic       kb_dat = 1'b1;
  logic [7:0] code;
  logic       code_valid;
  logic       err_start, err_parity, err_stop;

  int checks = 0;
  int errors = 0;
  int nvalid = 0;
  logic [7:0] last_code = 8'h00;

  always #2.5 clk = ~clk;

  kbd_frame_rx #(.DATA_W(8), .SYNC_STAGES(2), .IDLE_CYCLES(IDLE)) uut (
    .clk        (clk),
    .rst        (rst),
    .kb_clk     (kb_clk),
    .kb_dat     (kb_dat),
    .code       (code),
    .code_valid (code_valid),
    .err_start  (err_start),
    .err_parity (err_parity),
    .err_stop   (err_stop)
  );

  always @(negedge clk) begin
    if (!rst && code_valid) begin
      nvalid    <= nvalid + 1;
      last_code <= code;
    end
  end

  function automatic logic odd_par(input logic [7:0] d);
    return ~(^d);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    kb_dat = b;
    cycles(HALF);
    kb_clk = 1'b0;
    cycles(HALF);
    kb_clk = 1'b1;
  endtask

  task automatic send_frame(input logic [7:0] d, input logic sbit,
                            input logic pbit, input logic ebit);
    send_bit(sbit);
    for (int i = 0; i < 8; i++) send_bit(d[i]);
    send_bit(pbit);
    send_bit(ebit);
    kb_dat = 1'b1;
    cycles(HALF);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    kb_clk = 1'b1;
    kb_dat = 1'b1;
    cycles(4);
    rst = 1'b0;
    @(negedge clk);
    nvalid = 0;
  endtask

  task automatic good_frame(input logic [7:0] d, input string req);
    nvalid = 0;
    send_frame(d, 1'b0, odd_par(d), 1'b1);
    chk({req, " strobe count"}, nvalid, 1);
    chk({req, " code"}, last_code, d);
  endtask

  task automatic err_case(input string req, input logic [7:0] d,
                          input logic sb, input logic pb, input logic eb,
                          input logic [2:0] exp_flags);
    do_reset();
    send_frame(d, sb, pb, eb);
    chk({req, " flags"}, {err_start, err_parity, err_stop}, exp_flags);
    chk({req, " no strobe"}, nvalid, 0);
    send_frame(8'h3C, 1'b0, odd_par(8'h3C), 1'b1);
    chk("R6 lock flags", {err_start, err_parity, err_stop}, exp_flags);
    chk("R6 lock no strobe", nvalid, 0);
    chk("R6 lock code", code, 0);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    cycles(3);
    // R1 during reset
    chk("R1 code in reset", code, 0);
    chk("R1 flags in reset", {code_valid, err_start, err_parity, err_stop}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 code after reset", code, 0);
    chk("R1 flags after reset", {code_valid, err_start, err_parity, err_stop}, 0);
    nvalid = 0;

    // R2 directed corners
    good_frame(8'h00, "R2");
    good_frame(8'hFF, "R2");
    good_frame(8'h01, "R2");
    good_frame(8'h80, "R3");
    // R9 code held after strobe
    cycles(50);
    chk("R9 code held", code, 8'h80);

    // R2 random
    for (int k = 0; k < 24; k++) begin
      logic [7:0] d;
      d = 8'($urandom());
      good_frame(d, "R2");
    end

    // R8 idle recovery: truncated frame then long clock-high gap
    begin
      logic [7:0] d;
      d = 8'($urandom());
      nvalid = 0;
      send_bit(1'b0);
      send_bit(1'b1);
      send_bit(1'b0);
      send_bit(1'b1);
      kb_dat = 1'b1;
      cycles(IDLE + 60);
      chk("R8 no strobe from partial", nvalid, 0);
      good_frame(d, "R8");
      chk("R8 no error after recovery", {err_start, err_parity, err_stop}, 0);
    end

    // R3, R4, R5 and lock R6, one flag only R7
    err_case("R3", 8'h5A, 1'b0, ~odd_par(8'h5A), 1'b1, 3'b010);
    err_case("R3", 8'h07, 1'b0, ~odd_par(8'h07), 1'b1, 3'b010);
    err_case("R4", 8'h12, 1'b1, odd_par(8'h12), 1'b1, 3'b100);
    err_case("R5", 8'hA5, 1'b0, odd_par(8'hA5), 1'b0, 3'b001);

    // R1 reset clears lock, R7 flags clear
    do_reset();
    chk("R1 reset clears flags", {err_start, err_parity, err_stop}, 0);
    good_frame(8'h6B, "R1");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R2 actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule